// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block times the interval between successive rising edges of a fan tachometer signal, in clock cycles. The raw tach pin goes through a synchroniser and an edge detector. A counter then measures the cycles from one rising edge to the next. Each finished interval is latched onto a measurement output, and a one-cycle new-measurement event fires for an interrupt bank elsewhere in the chip.

Software programs a nominal period and a tolerance, both in clock cycles. Every finished interval is compared against the inclusive window nominal minus tolerance to nominal plus tolerance. An interval outside that window raises a one-cycle fault event alongside the measurement event. A common use is to take a fresh reading after a duty-cycle change and program the tolerance to a quarter of it. Software turns the count into a speed (60 × clock rate divided by pulses per revolution times count).

A fan that stops never produces another edge. The counter therefore saturates, publishes its ceiling value as a faulty reading, and waits for the next edge to start timing again. A published value of zero means that no reading exists.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, `meas_period` is 0 and both `meas_event` and `fault_event` are low.
- R2: The first rising edge seen after reset, after `en` goes high, or after a saturation only starts timing and raises no event.
- R3: Every later rising edge of `tach_in` publishes the number of clock cycles since the previous rising edge on `meas_period` and pulses `meas_event` for one cycle. The update appears after the third rising clock edge at which `tach_in` is sampled high, and `meas_period` holds its value between events.
- R4: A published interval below `expect_period - tolerance` or above `expect_period + tolerance` pulses `fault_event` in the same cycle as `meas_event`. The bounds are inclusive, and the lower bound floors at 0.
- R5: While `expect_period` is 0, no window fault is raised.
- R6: If timing reaches 2^CNT_W-1 cycles with no edge, that value is published with both events high, and timing stops until a new edge rearms it.
- R7: While `en` is low, `meas_period` is cleared to 0 on the next clock, no events are raised and tach edges are ignored.
- R8: Both events are single-cycle pulses, and `fault_event` is never high without `meas_event`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Monitor enable |
| tach_in | input | 1 | Raw asynchronous tachometer pin |
| expect_period | input | CNT_W | Nominal interval in cycles, 0 disables the window check |
| tolerance | input | CNT_W | Allowed deviation in cycles |
| meas_period | output | CNT_W | Latest published interval, 0 when none |
| meas_event | output | 1 | One-cycle pulse per published interval |
| fault_event | output | 1 | One-cycle pulse for an out-of-window or saturated interval |

## Verification
A rising tach level first sampled at clock edge k shows up as a detected edge before edge k+2. The published value and both events therefore change just after edge k+2, and a change of `en` takes effect on the outputs one edge after it is sampled. The bench's reference model replays exactly that timing: it keeps a three-deep history of sampled tach levels and the sampled control inputs at each rising edge, then compares all three outputs at the following falling edge. Scenario checks add the last captured value, its fault flag and event counts after each pulse train. These cover window boundaries, a floored lower bound, saturation and disable.

// File: rtl/tach_mon_pkg.sv
package tach_mon_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_TIMING = 1'b1
    } timer_state_e;

    localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/tach_edge_detect.sv
module tach_edge_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic rise_o
);
    import tach_mon_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.chain[0] = tach_in;
        for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            nxt_d.chain[i] = cur_q.chain[i-1];
        end
        nxt_d.last = cur_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rise_o = cur_q.chain[SYNC_STAGES-1] & ~cur_q.last;

    initial begin
        if (SYNC_STAGES < MIN_SYNC_STAGES) $error("SYNC_STAGES too small");
    end

    // R3: a detected edge needs a low level before it, so never two in a row
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tach_period_timer.sv
module tach_period_timer #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rise_i,
    output logic             pub_o,
    output logic             sat_o,
    output logic [CNT_W-1:0] val_o
);
    import tach_mon_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    typedef struct packed {
        timer_state_e     st;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        pub_o = 1'b0;
        sat_o = 1'b0;
        val_o = cur_q.cnt + 1'b1;
        if (!en_i) begin
            nxt_d.st  = ST_IDLE;
            nxt_d.cnt = '0;
        end else if (rise_i) begin
            pub_o     = (cur_q.st == ST_TIMING);
            nxt_d.st  = ST_TIMING;
            nxt_d.cnt = '0;
        end else if (cur_q.st == ST_TIMING) begin
            if (cur_q.cnt == CNT_LAST) begin
                pub_o     = 1'b1;
                sat_o     = 1'b1;
                nxt_d.st  = ST_IDLE;
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, cnt: '0};
        else        cur_q <= nxt_d;
    end

    // R2: an edge while idle only arms the timer from zero
    p_arm_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rise_i && cur_q.st == ST_IDLE) |=> (cur_q.st == ST_TIMING && cur_q.cnt == '0));

    // R6: the running count never reaches the ceiling itself
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_TIMING) |-> (cur_q.cnt != CNT_MAX));

    // R6: after saturation the timer is idle
    p_sat_idles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |=> (cur_q.st == ST_IDLE));
endmodule

// File: rtl/tach_window_check.sv
module tach_window_check #(
    parameter int unsigned CNT_W = 20
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic [CNT_W-1:0] nominal_i,
    input  logic [CNT_W-1:0] slack_i,
    output logic             outside_o
);
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] upper;
    logic [EXT_W-1:0] val_plus_slack;
    logic             too_low;
    logic             too_high;

    always_comb begin
        upper          = EXT_W'(nominal_i) + EXT_W'(slack_i);
        val_plus_slack = EXT_W'(val_i) + EXT_W'(slack_i);
        too_low        = val_plus_slack < EXT_W'(nominal_i);
        too_high       = EXT_W'(val_i) > upper;
        outside_o      = (nominal_i != '0) && (too_low || too_high);
    end

    // R5: a zero nominal never flags
    always_comb begin
        if (nominal_i == '0) a_zero_nominal_r5: assert (!outside_o);
    end
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tach_in,
    input  logic [CNT_W-1:0] expect_period,
    input  logic [CNT_W-1:0] tolerance,
    output logic [CNT_W-1:0] meas_period,
    output logic             meas_event,
    output logic             fault_event
);
    logic             rise;
    logic             pub;
    logic             sat;
    logic [CNT_W-1:0] val;
    logic             outside;

    tach_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tach_in (tach_in),
        .rise_o  (rise)
    );

    tach_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .rise_i (rise),
        .pub_o  (pub),
        .sat_o  (sat),
        .val_o  (val)
    );

    tach_window_check #(.CNT_W(CNT_W)) u_window (
        .val_i     (val),
        .nominal_i (expect_period),
        .slack_i   (tolerance),
        .outside_o (outside)
    );

    typedef struct packed {
        logic [CNT_W-1:0] meas;
        logic             evt;
        logic             flt;
    } out_t;

    out_t out_q, out_d;

    always_comb begin
        out_d     = out_q;
        out_d.evt = 1'b0;
        out_d.flt = 1'b0;
        if (!en) begin
            out_d.meas = '0;
        end else if (pub) begin
            out_d.meas = val;
            out_d.evt  = 1'b1;
            out_d.flt  = sat | outside;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign meas_period = out_q.meas;
    assign meas_event  = out_q.evt;
    assign fault_event = out_q.flt;

    // R8: fault only alongside a measurement
    p_fault_with_meas_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_event |-> meas_event);

    // R8: single-cycle event
    p_evt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        meas_event |=> !meas_event);

    // R7: disabled monitor is cleared and silent
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (meas_period == '0 && !meas_event && !fault_event));

    // R3: a published interval is never zero
    p_nonzero_meas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_event |-> (meas_period != '0));

    // R3: value holds between events while enabled
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !meas_event) |=> (!meas_event -> $stable(meas_period)) or meas_event or !en);
endmodule

// File: tb/sim_fan_tach_monitor.sv
`timescale 1ns/1ps
module sim_fan_tach_monitor;
    localparam int W   = 12;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         tach_in = 1'b0;
    logic [W-1:0] expect_period = '0;
    logic [W-1:0] tolerance = '0;
    logic [W-1:0] meas_period;
    logic         meas_event;
    logic         fault_event;

    always #2.5 clk = ~clk;

    fan_tach_monitor #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .tach_in(tach_in),
        .expect_period(expect_period), .tolerance(tolerance),
        .meas_period(meas_period), .meas_event(meas_event), .fault_event(fault_event)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, actual, expected, $time);
        end
    endtask

    // Behavioural reference: history of sampled tach levels and timing state
    int h1 = 0, h2 = 0, h3 = 0;
    bit armed = 0;
    int since = 0;
    int m_meas = 0, m_evt = 0, m_flt = 0;

    function automatic int off_window(input int v, input int nom, input int tol);
        if (nom == 0) return 0;
        if (v + tol < nom) return 1;
        if (v > nom + tol) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0; armed = 0; since = 0;
            m_meas = 0; m_evt = 0; m_flt = 0;
        end else begin
            bit edge_seen;
            edge_seen = (h2 == 1) && (h3 == 0);
            h3 = h2; h2 = h1; h1 = int'(tach_in);
            m_evt = 0; m_flt = 0;
            if (!en) begin
                armed = 0; since = 0; m_meas = 0;
            end else if (edge_seen) begin
                if (armed) begin
                    m_meas = since + 1; m_evt = 1;
                    m_flt = off_window(since + 1, int'(expect_period), int'(tolerance));
                end
                armed = 1; since = 0;
            end else if (armed) begin
                if (since == MAX - 1) begin
                    m_meas = MAX; m_evt = 1; m_flt = 1; armed = 0; since = 0;
                end else begin
                    since++;
                end
            end
        end
    end

    int evt_cnt = 0;
    int last_meas = 0;
    int last_flt = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 meas_period", int'(meas_period), m_meas);
            check("R8 meas_event", int'(meas_event), m_evt);
            check("R4 fault_event", int'(fault_event), m_flt);
            if (meas_event) begin
                evt_cnt++;
                last_meas = int'(meas_period);
                last_flt  = int'(fault_event);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic train(input int period, input int count);
        for (int p = 0; p < count; p++) begin
            tach_in = 1'b1;
            idle(3);
            tach_in = 1'b0;
            idle(period - 3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        idle(5);
        check("R1 reset meas", int'(meas_period), 0);
        check("R1 reset evt", int'(meas_event), 0);
        check("R1 reset flt", int'(fault_event), 0);
        rst_n = 1'b1;
        idle(3);
        en = 1'b1;

        // R2/R3/R5: free-running train with no window
        base = evt_cnt;
        train(50, 4);
        idle(4);
        check("R2 first edge silent", evt_cnt - base, 3);
        check("R3 period 50", last_meas, 50);
        check("R5 no window", last_flt, 0);

        // R4: window 100 +/- 10
        expect_period = 12'd100; tolerance = 12'd10;
        train(100, 3); idle(4);
        check("R4 nominal in", last_flt, 0);
        train(110, 2); idle(4);
        check("R4 upper bound value", last_meas, 110);
        check("R4 upper bound in", last_flt, 0);
        train(111, 2); idle(4);
        check("R4 above window", last_flt, 1);
        train(90, 2); idle(4);
        check("R4 lower bound in", last_flt, 0);
        train(89, 2); idle(4);
        check("R4 below window", last_flt, 1);

        // R4: lower bound floors at zero
        expect_period = 12'd5; tolerance = 12'd10;
        train(6, 3); idle(4);
        check("R4 floored lower bound", last_flt, 0);
        expect_period = 12'd40; tolerance = 12'd3;
        train(6, 3); idle(4);
        check("R4 short period", last_flt, 1);

        // R6: stalled fan saturates
        expect_period = '0; tolerance = '0;
        base = evt_cnt;
        idle(MAX + 20);
        check("R6 saturated value", last_meas, MAX);
        check("R6 saturated fault", last_flt, 1);
        check("R6 single publish", evt_cnt - base, 1);
        base = evt_cnt;
        train(40, 2); idle(4);
        check("R6 rearm on edge", evt_cnt - base, 1);
        check("R6 period after rearm", last_meas, 40);

        // R7: disable clears and ignores tach
        en = 1'b0;
        idle(2);
        check("R7 cleared", int'(meas_period), 0);
        base = evt_cnt;
        train(30, 3); idle(4);
        check("R7 ignored edges", evt_cnt - base, 0);
        check("R7 still zero", int'(meas_period), 0);
        en = 1'b1;
        base = evt_cnt;
        train(30, 3); idle(4);
        check("R2 re-enable first edge", evt_cnt - base, 2);
        check("R3 period 30", last_meas, 30);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule